// File: doc/BRIEF.md
# Packed Lane Add-Subtract-Compare Unit

This block is a single-stage vector ALU for 64-bit words. Each operand is viewed as eight byte lanes, four halfword lanes or two word lanes, and one operation is applied to every lane at once. Add and subtract come in three flavours: plain modular arithmetic, clamping to two's complement limits, and clamping to the unsigned range. Two compares, equality and signed greater-than, fill each lane with all ones or all zeros. These masks can then be combined with the full-width bitwise operations to select between two sources without branching.

A caller presents two operands, a lane-size code and an operation code together with a valid strobe. The result is registered and appears one clock later with its own valid strobe. No flags of any kind are produced; overflow either wraps inside the lane or is clamped.

Top module: `psac_unit`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid` and `out_result` are 0 after that edge.
- R2: `out_valid` equals `in_valid` delayed by one clock; `out_result` is loaded only on edges where `in_valid` is high and otherwise keeps its value.
- R3: `in_size` selects the lane width: 0 = 8-bit, 1 = 16-bit, 2 and 3 = 32-bit. Lane k occupies bits [k*W+W-1 : k*W].
- R4: Opcode 0 (add) and 3 (subtract a-b) wrap modulo 2^W inside each lane; no carry or borrow passes to the next lane.
- R5: Opcodes 1 (add) and 4 (subtract) saturate signed: a lane result above 2^(W-1)-1 becomes that value, one below -2^(W-1) becomes that value.
- R6: Opcodes 2 (add) and 5 (subtract) saturate unsigned: results above 2^W-1 become all ones, results below 0 become 0.
- R7: Opcode 6 sets a lane to all ones when the two lanes are equal and to all zeros otherwise.
- R8: Opcode 7 sets a lane to all ones when lane a is greater than lane b as signed numbers, and to all zeros otherwise.
- R9: Opcodes 8, 9, 10 and 11 give a AND b, a OR b, a XOR b and (NOT a) AND b over all 64 bits; `in_size` has no effect on them.
- R10: Opcodes 12 to 15 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and codes are valid this cycle |
| in_op | input | 4 | Operation code |
| in_size | input | 2 | Lane width code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result register was loaded on the last edge |
| out_result | output | 64 | Registered lane-wise result |

## Verification
The properties assume the operand and code inputs are steady around the clock edge at which `in_valid` is sampled, and that reset is applied for at least one edge before checking starts. The bench keeps to this by driving every input on the falling edge and sampling outputs on the next falling edge, one register after the strobe. Reserved lane-size and opcode values are driven on purpose, since their behaviour is defined.

// File: rtl/psac_pkg.sv
package psac_pkg;
  localparam logic [3:0] OP_ADD_WRAP = 4'd0;
  localparam logic [3:0] OP_ADD_SSAT = 4'd1;
  localparam logic [3:0] OP_ADD_USAT = 4'd2;
  localparam logic [3:0] OP_SUB_WRAP = 4'd3;
  localparam logic [3:0] OP_SUB_SSAT = 4'd4;
  localparam logic [3:0] OP_SUB_USAT = 4'd5;
  localparam logic [3:0] OP_CMP_EQ   = 4'd6;
  localparam logic [3:0] OP_CMP_GT   = 4'd7;
  localparam logic [3:0] OP_AND      = 4'd8;
  localparam logic [3:0] OP_OR       = 4'd9;
  localparam logic [3:0] OP_XOR      = 4'd10;
  localparam logic [3:0] OP_ANDN     = 4'd11;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/psac_lane_unit.sv
module psac_lane_unit
  import psac_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO = {W{1'b0}};

  logic [W:0] sum_x;
  logic [W:0] dif_x;
  logic       sovf_add;
  logic       sovf_sub;

  always_comb begin
    sum_x    = {1'b0, a} + {1'b0, b};
    dif_x    = {1'b0, a} - {1'b0, b};
    sovf_add = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
    sovf_sub = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
  end

  always_comb begin
    case (op)
      OP_ADD_WRAP: y = sum_x[W-1:0];
      OP_ADD_SSAT: y = sovf_add ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
      OP_ADD_USAT: y = sum_x[W] ? ONES : sum_x[W-1:0];
      OP_SUB_WRAP: y = dif_x[W-1:0];
      OP_SUB_SSAT: y = sovf_sub ? (a[W-1] ? SMIN : SMAX) : dif_x[W-1:0];
      OP_SUB_USAT: y = dif_x[W] ? ZERO : dif_x[W-1:0];
      OP_CMP_EQ:   y = (a == b) ? ONES : ZERO;
      OP_CMP_GT:   y = ($signed(a) > $signed(b)) ? ONES : ZERO;
      default:     y = ZERO;
    endcase
  end
endmodule

// File: rtl/psac_lane_array.sv
module psac_lane_array #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        op,
  output logic [DATA_W-1:0] y
);
  localparam int N_LANES = DATA_W / LANE_W;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    psac_lane_unit #(.W(LANE_W)) u_lane (
      .a  (a[k*LANE_W +: LANE_W]),
      .b  (b[k*LANE_W +: LANE_W]),
      .op (op),
      .y  (y[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/psac_logic.sv
module psac_logic
  import psac_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        op,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_ANDN: y = ~a & b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/psac_unit.sv
module psac_unit
  import psac_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  localparam int MID_W  = 2 * NARROW_W;
  localparam int WIDE_W = 4 * NARROW_W;

  logic [DATA_W-1:0] res_n, res_m, res_w, res_l, res_next;

  psac_lane_array #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_arr_n (
    .a(in_a), .b(in_b), .op(in_op), .y(res_n));
  psac_lane_array #(.DATA_W(DATA_W), .LANE_W(MID_W)) u_arr_m (
    .a(in_a), .b(in_b), .op(in_op), .y(res_m));
  psac_lane_array #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) u_arr_w (
    .a(in_a), .b(in_b), .op(in_op), .y(res_w));
  psac_logic #(.DATA_W(DATA_W)) u_logic (
    .a(in_a), .b(in_b), .op(in_op), .y(res_l));

  always_comb begin
    if (in_op[3]) begin
      res_next = res_l;
    end else begin
      case (in_size)
        SZ_BYTE: res_next = res_n;
        SZ_HALF: res_next = res_m;
        default: res_next = res_w;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= res_next;
    end
  end
endmodule

// File: rtl/psac_unit_chk.sv
module psac_unit_chk
  import psac_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        in_op,
  input logic [1:0]        in_size,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result
);
  function automatic logic is_byte_mask(input logic [DATA_W-1:0] v);
    logic ok = 1'b1;
    for (int k = 0; k < DATA_W / 8; k++)
      if (v[k*8 +: 8] != 8'h00 && v[k*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));

  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result)));

  a_r5_ssat_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ADD_SSAT && in_size == SZ_BYTE && !in_a[7] && !in_b[7])
      |=> !out_result[7]);

  a_r6_usat_floor: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ADD_USAT && in_size == 2'd2)
      |=> out_result[31:0] >= $past(in_a[31:0]));

  a_r7_eq_self: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_CMP_EQ && in_a == in_b) |=> (out_result == '1));

  a_r8_mask_shape: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_CMP_GT && in_size == SZ_BYTE) |=> is_byte_mask(out_result));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[3] && in_op[2]) |=> (out_result == '0));
endmodule

bind psac_unit psac_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result));

// File: tb/tb_psac_unit.sv
module tb_psac_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [1:0]  in_size;
  logic [63:0] in_a, in_b;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psac_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result));

  // {req[3:0], op[3:0], size[1:0], a, b, expected}
  localparam int NV = 24;
  localparam logic [201:0] VEC [NV] = '{
    // R4 wrap add, three lane sizes: carries must stop at lane edges
    {4'd4, 4'd0, 2'd0, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h0000_FF00_FFFF_FF00},
    {4'd4, 4'd0, 2'd1, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h0000_0000_FFFF_0000},
    {4'd4, 4'd0, 2'd2, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h0001_0000_0000_0000},
    {4'd4, 4'd0, 2'd0, 64'h01FF_7F80_0000_0010, 64'h0101_0180_0000_0020, 64'h0200_8000_0000_0030},
    // R3 size code 3 acts as 32-bit lanes
    {4'd3, 4'd0, 2'd3, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h0001_0000_0000_0000},
    // R4 wrap subtract: borrow stays inside the lane
    {4'd4, 4'd3, 2'd0, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_01FF},
    {4'd4, 4'd3, 2'd1, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_00FF},
    // R5 signed saturation
    {4'd5, 4'd1, 2'd0, 64'h7F80_7F80_10F0_40C0, 64'h01FF_8080_20F0_40C0, 64'h7F80_FF80_30E0_7F80},
    {4'd5, 4'd4, 2'd1, 64'h7FFF_8000_0000_8000, 64'hFFFF_0001_8000_7FFF, 64'h7FFF_8000_7FFF_8000},
    // R6 unsigned saturation
    {4'd6, 4'd2, 2'd0, 64'hFF80_0100_F00F_00FE, 64'h0180_0100_0FF0_0001, 64'hFFFF_0200_FFFF_00FF},
    {4'd6, 4'd5, 2'd2, 64'h0000_0005_FFFF_FFFF, 64'h0000_0006_0000_0001, 64'h0000_0000_FFFF_FFFE},
    {4'd6, 4'd5, 2'd0, 64'h0000_0005_FFFF_FFFF, 64'h0000_0006_0000_0001, 64'h0000_0000_FFFF_FFFE},
    // R7 equality masks
    {4'd7, 4'd6, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3344_0066_7700, 64'hFF00_FFFF_00FF_FF00},
    {4'd7, 4'd6, 2'd1, 64'h1122_3344_5566_7788, 64'h1100_3344_0066_7700, 64'h0000_FFFF_0000_0000},
    // R8 signed greater-than masks
    {4'd8, 4'd7, 2'd0, 64'h0180_7FFF_0005_80FF, 64'h007F_8000_0005_FFFE, 64'hFF00_FF00_0000_00FF},
    {4'd8, 4'd7, 2'd2, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    // R9 full-width logic, size code varied
    {4'd9, 4'd8, 2'd1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_F000_F000},
    {4'd9, 4'd9, 2'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hFFF0_FFF0_FFF0_FFF0},
    {4'd9, 4'd10, 2'd2, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0},
    {4'd9, 4'd11, 2'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0F00_0F00_0F00_0F00},
    {4'd9, 4'd11, 2'd2, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0F00_0F00_0F00_0F00},
    // R10 reserved opcodes give zero
    {4'd10, 4'd12, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h0},
    {4'd10, 4'd15, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h0},
    {4'd4, 4'd3, 2'd2, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF}
  };

  task automatic check64(input int req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: result %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input int req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: valid %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_size = '0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check1(1, out_valid, 1'b0);
    check64(1, out_result, 64'h0);
    rst = 1'b0;

    // Table walk: drive on falling edge, sample one edge later (R2 valid)
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_op    = VEC[i][197:194];
      in_size  = VEC[i][193:192];
      in_a     = VEC[i][191:128];
      in_b     = VEC[i][127:64];
      @(negedge clk);
      check1(2, out_valid, 1'b1);
      check64(int'(VEC[i][201:198]), out_result, VEC[i][63:0]);
    end

    // R2: idle cycles keep the result and drop valid
    in_valid = 1'b1; in_op = 4'd9; in_size = 2'd0;
    in_a = 64'h0123_4567_89AB_CDEF; in_b = 64'h0;
    @(negedge clk);
    check64(2, out_result, 64'h0123_4567_89AB_CDEF);
    in_valid = 1'b0; in_op = 4'd8; in_a = 64'h0; in_b = 64'h0;
    @(negedge clk);
    check1(2, out_valid, 1'b0);
    check64(2, out_result, 64'h0123_4567_89AB_CDEF);
    @(negedge clk);
    check64(2, out_result, 64'h0123_4567_89AB_CDEF);

    // R1: reset mid-run clears a loaded result
    rst = 1'b1; in_valid = 1'b1; in_op = 4'd9; in_a = '1;
    @(negedge clk);
    check1(1, out_valid, 1'b0);
    check64(1, out_result, 64'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check1(2, out_valid, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule